// File: doc/BRIEF.md
# Sixteen-Round Feistel Block Cipher Engine

This block enciphers or deciphers one 64-bit block at a time using a sixteen-round Feistel network. The network is keyed by an array of eighteen 32-bit subkeys and by four substitution tables, each holding 256 words of 32 bits. Software or a neighbouring block first fills the subkeys and tables through a write port. It then pulses `start` with a block on `din` and the direction on `decrypt`. Some fixed number of cycles later, `done` pulses for one cycle and the result appears on `dout`.

Each round folds a subkey into the upper (left) half. It then passes that half through the mixing function, which reads all four tables and combines the results. The mixed value is folded into the lower half, and the two halves trade places. After the sixteenth round the final trade is undone and both halves are whitened with the two remaining subkeys. Deciphering runs the same datapath and walks the subkey array from the other end.

Rounds depend on one another, so they run strictly in sequence. The parameter `TABLE_READ_REG` selects between two table styles. With table reads that settle in the same cycle, a round takes one clock. With registered, RAM-style table reads, a round takes two clocks.

Top module: `feistel_engine`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `dout` is all zeros until the first operation completes.
- R2: With `decrypt`=0, the result is sixteen rounds over the block. The left half is `din[63:32]`. Round k (k = 1..16) XORs subkey k into the left half, XORs the mixing function of the new left half into the right half, and then swaps the halves. After round 16 the swap is undone, subkey 17 is XORed into the right half and subkey 18 into the left half. `dout` = {left, right}.
- R3: The mixing function splits its 32-bit input into bytes a (bits 31:24), b, c and d (bits 7:0). It returns ((T1[a] + T2[b]) XOR T3[c]) + T4[d], with both additions modulo 2^32.
- R4: With `decrypt`=1, the engine applies subkeys 18 down to 3 in the rounds, subkey 2 to the right half and subkey 1 to the left half. Deciphering an enciphered block returns the original block.
- R5: `done` is high for exactly one cycle, 16 × (cycles per round) rising edges after the edge that accepted `start`. `dout` changes only on that edge and holds its value until the next completion.
- R6: A `start` pulse that arrives while an operation is in progress is ignored. The running operation completes with its own result, and no second result follows.
- R7: Writes to the subkeys or tables while an operation is in progress are ignored. Later results use the old contents.
- R8: Write encoding, applied when `wr_en`=1 and the engine is idle. `wr_sel`=0 writes subkey `wr_idx`+1, for `wr_idx` 0..17. `wr_sel`=1..4 writes entry `wr_idx` of table 1..4. A `wr_sel` of 5..7, or a subkey write with `wr_idx` ≥ 18, changes nothing.
- R9: With `TABLE_READ_REG`=0 a round takes 1 cycle (completion 16 edges after start). With `TABLE_READ_REG`=1 a round takes 2 cycles (completion 32 edges after start). Both settings give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation on `din` when idle |
| decrypt | input | 1 | 1 selects deciphering, sampled with `start` |
| din | input | 64 | Input block, left half in the upper 32 bits |
| dout | output | 64 | Result block, held until the next completion |
| done | output | 1 | One-cycle pulse when `dout` is updated |
| wr_en | input | 1 | Write strobe for subkeys and tables |
| wr_sel | input | 3 | 0 subkeys, 1..4 tables, others ignored |
| wr_idx | input | 8 | Subkey index (0..17) or table entry (0..255) |
| wr_data | input | 32 | Word to write |

## Verification
The assertions assume that subkey writes only reach the store with an index below eighteen. They also assume that `start`, `decrypt` and `din` are valid whenever `start` is high. The stimulus keeps writes and starts apart: it never writes in the cycle it starts an operation. It issues busy-time writes only while both engine variants are mid-operation, so a single reference table copy serves both instances. Out-of-range indices and selects are driven on purpose, but only while the engine is idle, where the decoder filters them before they reach storage.

// File: rtl/feistel_pkg.sv
package feistel_pkg;
  localparam int HALF_W   = 32;
  localparam int BLK_W    = 2 * HALF_W;
  localparam int NROUNDS  = 16;
  localparam int NKEYS    = NROUNDS + 2;
  localparam int NTABLES  = 4;
  localparam int TAB_AW   = 8;
  localparam int TAB_N    = 1 << TAB_AW;
  localparam int SEL_W    = 3;
  localparam int RND_W    = $clog2(NROUNDS);
  localparam int KIDX_W   = $clog2(NKEYS);

  typedef enum logic [SEL_W-1:0] {
    SEL_KEY = 3'd0,
    SEL_T1  = 3'd1,
    SEL_T2  = 3'd2,
    SEL_T3  = 3'd3,
    SEL_T4  = 3'd4
  } wsel_e;
endpackage

// File: rtl/feistel_subkeys.sv
module feistel_subkeys #(
  parameter int W  = 32,
  parameter int NK = 18,
  localparam int IW = $clog2(NK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra0,
  input  logic [IW-1:0] ra1,
  input  logic [IW-1:0] ra2,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] mem [NK];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];

  // R8: the decoder never lets an out-of-range subkey index reach storage
  assert_key_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(widx) < NK));
endmodule

// File: rtl/feistel_sboxes.sv
module feistel_sboxes #(
  parameter int W       = 32,
  parameter int NT      = 4,
  parameter int AW      = 8,
  parameter bit REG_OUT = 1'b0,
  localparam int N = 1 << AW
) (
  input  logic                 clk,
  input  logic                 rd_en,
  input  logic [NT-1:0]        we,
  input  logic [AW-1:0]        widx,
  input  logic [W-1:0]         wdata,
  input  logic [W-1:0]         key_word,
  output logic [NT-1:0][W-1:0] vals
);
  for (genvar t = 0; t < NT; t++) begin : g_tab
    logic [W-1:0]  mem [N];
    logic [AW-1:0] addr;

    assign addr = key_word[W-1-AW*t -: AW];

    always_ff @(posedge clk) begin
      if (we[t]) begin
        mem[widx] <= wdata;
      end
    end

    if (REG_OUT) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rd_en) begin
          q <= mem[addr];
        end
      end
      assign vals[t] = q;
    end else begin : g_comb
      assign vals[t] = rd_en ? mem[addr] : '0;
    end
  end
endmodule

// File: rtl/feistel_mix.sv
module feistel_mix #(
  parameter int W  = 32,
  parameter int NT = 4
) (
  input  logic [NT-1:0][W-1:0] vals,
  output logic [W-1:0]         f_out
);
  logic [W-1:0] sum01;
  logic [W-1:0] x2;

  always_comb begin
    sum01 = vals[0] + vals[1];
    x2    = sum01 ^ vals[2];
    f_out = x2 + vals[3];
  end
endmodule

// File: rtl/feistel_engine.sv
module feistel_engine
  import feistel_pkg::*;
#(
  parameter bit TABLE_READ_REG = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        decrypt,
  input  logic [63:0] din,
  output logic [63:0] dout,
  output logic        done,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_idx,
  input  logic [31:0] wr_data
);
  localparam int RC    = TABLE_READ_REG ? 2 : 1;
  localparam int PW    = (RC > 1) ? $clog2(RC) : 1;
  localparam int LAT   = NROUNDS * RC;
  localparam int LAT_W = $clog2(LAT + 1) + 1;

  // state
  logic              busy_q, busy_d;
  logic              dec_q, dec_d;
  logic [RND_W-1:0]  rnd_q, rnd_d;
  logic [PW-1:0]     ph_q, ph_d;
  logic [HALF_W-1:0] lh_q, lh_d, rh_q, rh_d;
  logic [BLK_W-1:0]  dout_q, dout_d;
  logic              done_q, done_d;
  logic              ctl_en;
  logic [LAT_W-1:0]  lat_q;

  // datapath
  logic [KIDX_W-1:0] rk_idx, finl_idx, finr_idx;
  logic [HALF_W-1:0] rk, k_finl, k_finr;
  logic [HALF_W-1:0] xl, f_val;
  logic [NTABLES-1:0][HALF_W-1:0] tvals;
  logic              step;

  // write decode
  logic               wr_ok, key_we;
  logic [NTABLES-1:0] tab_we;

  always_comb begin
    wr_ok  = wr_en && !busy_q;
    key_we = wr_ok && (wr_sel == SEL_KEY) && (int'(wr_idx) < NKEYS);
    for (int t = 0; t < NTABLES; t++) begin
      tab_we[t] = wr_ok && (wr_sel == SEL_W'(t + 1));
    end
  end

  always_comb begin
    rk_idx   = dec_q ? (KIDX_W'(NKEYS - 1) - KIDX_W'(rnd_q)) : KIDX_W'(rnd_q);
    finl_idx = dec_q ? KIDX_W'(0) : KIDX_W'(NKEYS - 1);
    finr_idx = dec_q ? KIDX_W'(1) : KIDX_W'(NKEYS - 2);
  end

  feistel_subkeys #(.W(HALF_W), .NK(NKEYS)) i_keys (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (key_we),
    .widx  (wr_idx[KIDX_W-1:0]),
    .wdata (wr_data),
    .ra0   (rk_idx),
    .ra1   (finl_idx),
    .ra2   (finr_idx),
    .rd0   (rk),
    .rd1   (k_finl),
    .rd2   (k_finr)
  );

  assign xl = lh_q ^ rk;

  feistel_sboxes #(.W(HALF_W), .NT(NTABLES), .AW(TAB_AW), .REG_OUT(TABLE_READ_REG)) i_tabs (
    .clk      (clk),
    .rd_en    (busy_q),
    .we       (tab_we),
    .widx     (wr_idx),
    .wdata    (wr_data),
    .key_word (xl),
    .vals     (tvals)
  );

  feistel_mix #(.W(HALF_W), .NT(NTABLES)) i_mix (
    .vals  (tvals),
    .f_out (f_val)
  );

  // next state
  always_comb begin
    busy_d = busy_q;
    dec_d  = dec_q;
    rnd_d  = rnd_q;
    ph_d   = ph_q;
    lh_d   = lh_q;
    rh_d   = rh_q;
    dout_d = dout_q;
    done_d = 1'b0;
    step   = busy_q && (ph_q == PW'(RC - 1));
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        dec_d  = decrypt;
        rnd_d  = '0;
        ph_d   = '0;
        lh_d   = din[BLK_W-1:HALF_W];
        rh_d   = din[HALF_W-1:0];
      end
    end else if (step) begin
      lh_d = rh_q ^ f_val;
      rh_d = xl;
      ph_d = '0;
      if (rnd_q == RND_W'(NROUNDS - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        dout_d = {xl ^ k_finl, (rh_q ^ f_val) ^ k_finr};
      end else begin
        rnd_d = rnd_q + RND_W'(1);
      end
    end else begin
      ph_d = ph_q + PW'(1);
    end
  end

  assign ctl_en = start || busy_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dec_q  <= 1'b0;
      rnd_q  <= '0;
      ph_q   <= '0;
      lh_q   <= '0;
      rh_q   <= '0;
      dout_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (ctl_en) begin
        busy_q <= busy_d;
        dec_q  <= dec_d;
        rnd_q  <= rnd_d;
        ph_q   <= ph_d;
        lh_q   <= lh_d;
        rh_q   <= rh_d;
      end
      if (done_d) begin
        dout_q <= dout_d;
      end
      done_q <= done_d;
    end
  end

  assign dout = dout_q;
  assign done = done_q;

  // cycles since the accepted start, for the latency check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (!busy_q && start) begin
      lat_q <= '0;
    end else if (busy_q) begin
      lat_q <= lat_q + LAT_W'(1);
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (lat_q == LAT_W'(LAT)));

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q));

  assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_q) |-> done_q);

  // R6: a busy engine keeps running its round sequence whatever start does
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_d) |=> (busy_q && (rnd_q >= $past(rnd_q))));
endmodule

// File: tb/test_feistel_engine.sv
module test_feistel_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        start, decrypt;
  logic [63:0] din;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_idx;
  logic [31:0] wr_data;
  logic [63:0] dout_a, dout_b;
  logic        done_a, done_b;

  feistel_engine #(.TABLE_READ_REG(1'b0)) i_feistel_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt), .din(din),
    .dout(dout_a), .done(done_a), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data));

  feistel_engine #(.TABLE_READ_REG(1'b1)) i_feistel_engine_sync (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt), .din(din),
    .dout(dout_b), .done(done_b), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  string cur_tag = "R1";

  // reference state
  logic [31:0] rp [18];
  logic [31:0] rs [4][256];

  function automatic logic [31:0] ref_f(input logic [31:0] v);
    return ((rs[0][v[31:24]] + rs[1][v[23:16]]) ^ rs[2][v[15:8]]) + rs[3][v[7:0]];
  endfunction

  function automatic logic [63:0] ref_cipher(input logic [63:0] x, input logic dec);
    logic [31:0] l, r, k, t;
    l = x[63:32];
    r = x[31:0];
    for (int i = 0; i < 16; i++) begin
      k = dec ? rp[17 - i] : rp[i];
      l = l ^ k;
      r = r ^ ref_f(l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ (dec ? rp[1] : rp[16]);
    l = l ^ (dec ? rp[0] : rp[17]);
    return {l, r};
  endfunction

  // cycle model
  int          cnt_a, cnt_b;
  logic [63:0] pend_a, pend_b, exp_dout_a, exp_dout_b;
  logic        exp_done_a, exp_done_b;
  logic        idle_a, idle_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a = 0; cnt_b = 0;
      exp_done_a = 1'b0; exp_done_b = 1'b0;
      exp_dout_a = '0; exp_dout_b = '0;
      pend_a = '0; pend_b = '0;
    end else begin
      idle_a = (cnt_a == 0);
      idle_b = (cnt_b == 0);
      exp_done_a = 1'b0;
      exp_done_b = 1'b0;
      if (!idle_a) begin
        cnt_a--;
        if (cnt_a == 0) begin exp_done_a = 1'b1; exp_dout_a = pend_a; end
      end else if (start) begin
        pend_a = ref_cipher(din, decrypt);
        cnt_a = 16;
      end
      if (!idle_b) begin
        cnt_b--;
        if (cnt_b == 0) begin exp_done_b = 1'b1; exp_dout_b = pend_b; end
      end else if (start) begin
        pend_b = ref_cipher(din, decrypt);
        cnt_b = 32;
      end
      if (wr_en && idle_a && idle_b) begin
        if (wr_sel == 3'd0 && wr_idx < 8'd18) rp[wr_idx] = wr_data;
        else if (wr_sel >= 3'd1 && wr_sel <= 3'd4) rs[wr_sel - 3'd1][wr_idx] = wr_data;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_tag, " R5 done fast"}, {63'd0, done_a}, {63'd0, exp_done_a});
      chk({cur_tag, " R9 done regd"}, {63'd0, done_b}, {63'd0, exp_done_b});
      chk({cur_tag, " R2 dout fast"}, dout_a, exp_dout_a);
      chk({cur_tag, " R9 dout regd"}, dout_b, exp_dout_b);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R5 watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input logic [63:0] blk, input logic dec, output logic [63:0] res);
    int na, nb;
    start = 1'b1; din = blk; decrypt = dec;
    @(negedge clk);
    start = 1'b0;
    na = -1; nb = -1;
    for (int n = 0; n < 40; n++) begin
      if (done_a && na < 0) na = n;
      if (done_b && nb < 0) nb = n;
      @(negedge clk);
    end
    chk("R5 latency fast", 64'(na), 64'd16);
    chk("R9 latency regd", 64'(nb), 64'd32);
    chk("R9 variants agree", dout_b, dout_a);
    res = dout_a;
  endtask

  initial begin
    logic [63:0] p, c, q, r;
    rst_n = 1'b0; start = 1'b0; decrypt = 1'b0; din = '0;
    wr_en = 1'b0; wr_sel = '0; wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset done", {62'd0, done_a, done_b}, 64'd0);
    chk("R1 reset dout fast", dout_a, 64'd0);
    chk("R1 reset dout regd", dout_b, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset dout", dout_a, 64'd0);

    cur_tag = "R8";
    for (int t = 1; t <= 4; t++)
      for (int j = 0; j < 256; j++) wr(3'(t), 8'(j), $urandom);
    for (int k = 0; k < 18; k++) wr(3'd0, 8'(k), $urandom);

    cur_tag = "R2";
    for (int n = 0; n < 5; n++) begin
      p = {$urandom, $urandom};
      run(p, 1'b0, c);
      chk("R2 encrypt", c, ref_cipher(p, 1'b0));
    end
    run(64'd0, 1'b0, c);
    chk("R2 encrypt zero block", c, ref_cipher(64'd0, 1'b0));

    cur_tag = "R4";
    for (int n = 0; n < 4; n++) begin
      p = {$urandom, $urandom};
      run(p, 1'b0, c);
      run(c, 1'b1, q);
      chk("R4 decrypt roundtrip", q, p);
      chk("R4 decrypt model", q, ref_cipher(c, 1'b1));
    end

    cur_tag = "R6";
    p = {$urandom, $urandom};
    start = 1'b1; din = p; decrypt = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; din = ~p; decrypt = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R6 busy start ignored", dout_a, ref_cipher(p, 1'b0));
    chk("R6 busy start ignored regd", dout_b, ref_cipher(p, 1'b0));

    cur_tag = "R7";
    p = {$urandom, $urandom};
    r = ref_cipher(p, 1'b0);
    start = 1'b1; din = p; decrypt = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    wr(3'd0, 8'd0, ~rp[0]);
    wr(3'd2, p[55:48], 32'hDEADBEEF);
    repeat (40) @(negedge clk);
    chk("R7 busy result", dout_a, r);
    run(p, 1'b0, c);
    chk("R7 busy writes ignored", c, r);

    cur_tag = "R8";
    p = {$urandom, $urandom};
    r = ref_cipher(p, 1'b0);
    wr(3'd5, 8'd0, 32'h12345678);
    wr(3'd7, p[63:56], 32'h0F0F0F0F);
    wr(3'd0, 8'd18, 32'hFFFFFFFF);
    wr(3'd0, 8'd200, 32'hAAAAAAAA);
    run(p, 1'b0, c);
    chk("R8 invalid writes ignored", c, r);
    wr(3'd0, 8'd17, rp[17] ^ 32'h1);
    run(p, 1'b0, c);
    chk("R8 subkey 18 write", c, r ^ 64'h0000_0001_0000_0000);

    cur_tag = "R3";
    for (int k = 0; k < 18; k++) wr(3'd0, 8'(k), 32'd0);
    for (int j = 0; j < 256; j++) begin
      wr(3'd1, 8'(j), 32'(j) << 24);
      wr(3'd2, 8'(j), 32'hFFFF_FF00 | 32'(j));
      wr(3'd3, 8'(j), 32'h8000_0001 * 32'(j + 1));
      wr(3'd4, 8'(j), ~(32'(j) << 8));
    end
    p = 64'h0123_4567_89AB_CDEF;
    run(p, 1'b0, c);
    chk("R3 mixing function", c, ref_cipher(p, 1'b0));
    run(c, 1'b1, q);
    chk("R3 R4 roundtrip", q, p);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule